// File: doc/BRIEF.md
# Secure Decrypt Control Sequencer

This block is the control and status front end of an inline decryption engine. Software reaches it through a simple single-cycle register port. A control word holds several things: the decryption enable, two forced operating modes, an injected error, an interrupt enable, a set-only restricted-access lock, a scramble enable for wrapped keys, an unwrap enable, and a start request for the key-unwrap operation. A small bank of protected words holds keys or context for the datapath. The bank is presented on a flat output bus, and the lock makes it read as zero and refuse writes.

The key-unwrap request can be issued once per hard reset. Once issued, it waits until the upstream bus arbiter reports idle. The block then raises a busy signal toward the crypto core and holds it until the core signals completion. At that point a done status bit is set and stays set, and an optional one-cycle interrupt is raised.

Register map (word addresses): 0 is the control word, 1 is the read-only status word, and 2 up to 2+NUM_PROT-1 are the protected words.

Top module: `dec_ctrl_seq`

## Requirements
- R1: After reset, every control bit, the status word, all protected words and all outputs read as zero.
- R2: Control bits 0 (decrypt enable), 1 (force mode A), 2 (force mode B), 4 (interrupt enable), 6 (scramble enable) and 7 (unwrap enable) take the written value, read back at address 0, and drive their outputs the cycle after the write. Clearing bit 0 changes no other bit.
- R3: Control bit 8 (start) can be set only once per reset. Once it reads 1, later writes of 0 or 1 to it are ignored until reset.
- R4: The write that sets bit 8 launches an unwrap only if the same write also sets bit 7. Otherwise the start is consumed and the sequencer stays idle. Status bit 2 (pending) reads 1 from the cycle after a launching write.
- R5: A pending request waits while bus_idle_i is low. The first clock edge that samples bus_idle_i high clears pending and sets status bit 3 and unwrap_busy_o.
- R6: While busy, a clock edge sampling unwrap_done_i high clears busy and sets status bit 0 (done). Done stays set until reset, and no later start write changes the state.
- R7: When done rises with control bit 4 set, irq_o is high for exactly the cycle in which done first reads 1. If bit 4 is clear, irq_o stays low.
- R8: Control bit 5 (restricted) is set-only. Writing 0 to it has no effect. Status bit 1 mirrors it.
- R9: While unrestricted, protected word i is written at address 2+i, reads back there, and appears on prot_words_o bits [i*DATA_W +: DATA_W]. While restricted, those addresses read 0 and writes leave prot_words_o unchanged.
- R10: err_o equals control bit 3 (force error) whatever the sequencer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Combinational read data for reg_addr_i |
| bus_idle_i | input | 1 | Upstream bus arbiter reports idle |
| unwrap_done_i | input | 1 | Crypto core finished the unwrap |
| unwrap_busy_o | output | 1 | Unwrap in progress, request to crypto core |
| decrypt_en_o | output | 1 | Global decryption enable |
| force_a_o | output | 1 | Forced operating mode A |
| force_b_o | output | 1 | Forced operating mode B |
| scramble_en_o | output | 1 | Wrapped-key scramble enable |
| prot_words_o | output | NUM_PROT*DATA_W | Protected key/context words |
| irq_o | output | 1 | One-cycle completion interrupt |
| err_o | output | 1 | Forced error indication |

## Verification
A sequencer stuck in the wrong state appears within one clock at status bits 0, 2 and 3 and on unwrap_busy_o. Examples are a start that is accepted twice, a launch without bus idle, or a done that falls back. Each of these shows up on the read immediately after the stimulus edge. A lock that fails to hold appears as a nonzero read, or as a change on prot_words_o, one cycle after a write to a protected address. A misplaced interrupt shows as irq_o out of step with the done bit, or wider than one cycle.

// File: rtl/dec_ctrl_pkg.sv
package dec_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_BUS = 2'd1,
    ST_PROC     = 2'd2,
    ST_DONE     = 2'd3
  } unwrap_state_e;

  // field order sets the bit positions software uses (bit 0 = glb_en)
  typedef struct packed {
    logic start;
    logic unwrap_en;
    logic scramble;
    logic restrict_en;
    logic irq_en;
    logic force_err;
    logic force_b;
    logic force_a;
    logic glb_en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_STAT = 1;
  localparam int unsigned ADDR_PROT = 2;

  localparam int unsigned STAT_DONE    = 0;
  localparam int unsigned STAT_RESTR   = 1;
  localparam int unsigned STAT_PENDING = 2;
  localparam int unsigned STAT_BUSY    = 3;
  localparam int unsigned STAT_W       = 4;

endpackage

// File: rtl/dec_ctrl_reg.sv
module dec_ctrl_reg
  import dec_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic              launch_o
);

  ctrl_t ctrl_q, ctrl_w, ctrl_d;
  logic  start_acc;

  assign ctrl_w = ctrl_t'(wdata_i);

  // start is accepted only while it has never been set since reset
  assign start_acc = wr_i & ctrl_w.start & ~ctrl_q.start;
  assign launch_o  = start_acc & ctrl_w.unwrap_en;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_i) begin
      ctrl_d             = ctrl_w;
      ctrl_d.restrict_en = ctrl_q.restrict_en | ctrl_w.restrict_en;
      ctrl_d.start       = ctrl_q.start | ctrl_w.start;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

endmodule

// File: rtl/dec_unwrap_fsm.sv
module dec_unwrap_fsm
  import dec_ctrl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic          bus_idle_i,
  input  logic          unwrap_done_i,
  output unwrap_state_e state_o,
  output logic          done_rise_o
);

  unwrap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (launch_i)      state_d = ST_WAIT_BUS;
      ST_WAIT_BUS: if (bus_idle_i)    state_d = ST_PROC;
      ST_PROC:     if (unwrap_done_i) state_d = ST_DONE;
      ST_DONE:                        state_d = ST_DONE;
      default:                        state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o     = state_q;
  assign done_rise_o = (state_q == ST_PROC) & unwrap_done_i;

endmodule

// File: rtl/dec_prot_regs.sv
module dec_prot_regs #(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic                        lock_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic [NUM_WORDS*DATA_W-1:0] words_o
);

  logic [DATA_W-1:0] words_q [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        words_q[g] <= '0;
      else if (wr_i && !lock_i && (idx_i == IDX_W'(g)))
        words_q[g] <= wdata_i;
    end
    assign words_o[g*DATA_W +: DATA_W] = words_q[g];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_WORDS; i++)
      if (!lock_i && (idx_i == IDX_W'(i))) rdata_o = words_q[i];
  end

endmodule

// File: rtl/dec_ctrl_seq.sv
module dec_ctrl_seq
  import dec_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_PROT = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       reg_we_i,
  input  logic [ADDR_W-1:0]          reg_addr_i,
  input  logic [DATA_W-1:0]          reg_wdata_i,
  output logic [DATA_W-1:0]          reg_rdata_o,
  input  logic                       bus_idle_i,
  input  logic                       unwrap_done_i,
  output logic                       unwrap_busy_o,
  output logic                       decrypt_en_o,
  output logic                       force_a_o,
  output logic                       force_b_o,
  output logic                       scramble_en_o,
  output logic [NUM_PROT*DATA_W-1:0] prot_words_o,
  output logic                       irq_o,
  output logic                       err_o
);

  localparam int unsigned IDX_W = (NUM_PROT > 1) ? $clog2(NUM_PROT) : 1;

  ctrl_t             ctrl;
  unwrap_state_e     state;
  logic              launch, done_rise, irq_q;
  logic              sel_ctrl, sel_stat, sel_prot;
  logic [ADDR_W-1:0] prot_off;
  logic [DATA_W-1:0] prot_rdata;
  logic [STAT_W-1:0] status;
  logic              sts_done, sts_restrict, sts_pending, ctrl_start;

  assign sel_ctrl = (reg_addr_i == ADDR_W'(ADDR_CTRL));
  assign sel_stat = (reg_addr_i == ADDR_W'(ADDR_STAT));
  assign prot_off = reg_addr_i - ADDR_W'(ADDR_PROT);
  assign sel_prot = (reg_addr_i >= ADDR_W'(ADDR_PROT)) && (prot_off < ADDR_W'(NUM_PROT));

  dec_ctrl_reg u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_we_i & sel_ctrl),
    .wdata_i  (reg_wdata_i[CTRL_W-1:0]),
    .ctrl_o   (ctrl),
    .launch_o (launch)
  );

  dec_unwrap_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .launch_i      (launch),
    .bus_idle_i    (bus_idle_i),
    .unwrap_done_i (unwrap_done_i),
    .state_o       (state),
    .done_rise_o   (done_rise)
  );

  dec_prot_regs #(
    .NUM_WORDS (NUM_PROT),
    .DATA_W    (DATA_W)
  ) u_prot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_we_i & sel_prot),
    .idx_i   (prot_off[IDX_W-1:0]),
    .wdata_i (reg_wdata_i),
    .lock_i  (ctrl.restrict_en),
    .rdata_o (prot_rdata),
    .words_o (prot_words_o)
  );

  // interrupt lines up with the first cycle done reads 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= done_rise & ctrl.irq_en;
  end

  assign sts_done     = (state == ST_DONE);
  assign sts_pending  = (state == ST_WAIT_BUS);
  assign unwrap_busy_o = (state == ST_PROC);
  assign sts_restrict = ctrl.restrict_en;
  assign ctrl_start   = ctrl.start;

  always_comb begin
    status               = '0;
    status[STAT_DONE]    = sts_done;
    status[STAT_RESTR]   = sts_restrict;
    status[STAT_PENDING] = sts_pending;
    status[STAT_BUSY]    = unwrap_busy_o;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (sel_ctrl)      reg_rdata_o = DATA_W'(ctrl);
    else if (sel_stat) reg_rdata_o = DATA_W'(status);
    else if (sel_prot) reg_rdata_o = prot_rdata;
  end

  assign decrypt_en_o  = ctrl.glb_en;
  assign force_a_o     = ctrl.force_a;
  assign force_b_o     = ctrl.force_b;
  assign scramble_en_o = ctrl.scramble;
  assign err_o         = ctrl.force_err;
  assign irq_o         = irq_q;

endmodule

// File: rtl/dec_ctrl_seq_chk.sv
module dec_ctrl_seq_chk #(
  parameter int unsigned PW = 128
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          irq_o,
  input logic          sts_done,
  input logic          sts_restrict,
  input logic          sts_pending,
  input logic          ctrl_start,
  input logic          unwrap_busy_o,
  input logic          bus_idle_i,
  input logic [PW-1:0] prot_words_o
);

  p_start_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_start |=> ctrl_start);

  p_busy_needs_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unwrap_busy_o) |-> $past(bus_idle_i) && $past(sts_pending));

  p_done_terminal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_done |=> sts_done && !unwrap_busy_o && !sts_pending);

  p_irq_one_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_irq_on_done_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> sts_done && $past(unwrap_busy_o));

  p_restrict_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_restrict |=> sts_restrict);

  p_locked_words_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_restrict |=> $stable(prot_words_o));

endmodule

bind dec_ctrl_seq dec_ctrl_seq_chk #(.PW(NUM_PROT*DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .irq_o         (irq_o),
  .sts_done      (sts_done),
  .sts_restrict  (sts_restrict),
  .sts_pending   (sts_pending),
  .ctrl_start    (ctrl_start),
  .unwrap_busy_o (unwrap_busy_o),
  .bus_idle_i    (bus_idle_i),
  .prot_words_o  (prot_words_o)
);

// File: tb/dec_ctrl_seq_tb_top.sv
module dec_ctrl_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int NP = 4;
  localparam int LAT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic bus_idle = 1'b0, ucore_done = 1'b0;
  logic busy, den, fa, fb, scr, irq, err;
  logic [NP*DW-1:0] words;

  int n_checks = 0;
  int n_fail = 0;
  int irq_cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_ctrl_seq #(.ADDR_W(AW), .DATA_W(DW), .NUM_PROT(NP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .bus_idle_i(bus_idle),
    .unwrap_done_i(ucore_done), .unwrap_busy_o(busy), .decrypt_en_o(den),
    .force_a_o(fa), .force_b_o(fb), .scramble_en_o(scr),
    .prot_words_o(words), .irq_o(irq), .err_o(err)
  );

  always @(negedge clk) if (rst_n && irq) irq_cycles++;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; we = 1'b0; bus_idle = 1'b0; ucore_done = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    irq_cycles = 0;
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    addr = AW'(a);
    #1;
    d = rdata;
  endtask

  // control bit positions: 0 en,1 fa,2 fb,3 err,4 irq,5 restrict,6 scr,7 unwrap,8 start
  initial begin : main
    logic [DW-1:0] d;
    logic [NP*DW-1:0] snap;
    do_reset();

    // R1 reset state
    rd(0, d); check("R1 ctrl", d, 0);
    rd(1, d); check("R1 status", d, 0);
    for (int i = 0; i < NP; i++) begin rd(2 + i, d); check("R1 prot", d, 0); end
    check("R1 outputs", {busy, den, fa, fb, scr, irq, err, words}, 0);

    // R2 R10 sweep of all plain control bit patterns
    for (int p = 0; p < 128; p++) begin
      logic [DW-1:0] v;
      v = DW'({p[6], p[5], 1'b0, p[4:0]});
      wr(0, v);
      rd(0, d); check("R2 readback", d, v);
      check("R2 outputs", {den, fa, fb, scr}, {v[0], v[1], v[2], v[6]});
      check("R10 err", err, v[3]);
      rd(1, d); check("R4 no launch without start", d, 0);
    end
    // R2 clearing enable keeps others
    wr(0, 32'h0DF);
    wr(0, 32'h0DE);
    rd(0, d); check("R2 enable clear", d, 32'h0DE);
    check("R2 enable out", den, 1'b0);

    // R9 protected words normal access
    for (int i = 0; i < NP; i++) wr(2 + i, 32'hA500_0000 + 32'(i * 17));
    for (int i = 0; i < NP; i++) begin
      rd(2 + i, d); check("R9 prot read", d, 32'hA500_0000 + 32'(i * 17));
      check("R9 prot port", words[i*DW +: DW], 32'hA500_0000 + 32'(i * 17));
    end

    // R8 R9 restricted mode
    wr(0, 32'h020);
    rd(1, d); check("R8 status restricted", d[1], 1'b1);
    wr(0, 32'h000);
    rd(0, d); check("R8 set-only", d[5], 1'b1);
    rd(1, d); check("R8 status sticky", d[1], 1'b1);
    snap = words;
    for (int i = 0; i < NP; i++) begin
      rd(2 + i, d); check("R9 read as zero", d, 0);
      wr(2 + i, 32'h1234_5678);
      check("R9 write ignored", words, snap);
    end

    // R3 R4 start without unwrap enable is consumed
    do_reset();
    bus_idle = 1'b1;
    wr(0, 32'h100);
    rd(1, d); check("R4 consumed start idle", d, 0);
    wr(0, 32'h180);
    repeat (2) @(negedge clk);
    rd(1, d); check("R3 second start ignored", d, 0);
    check("R3 busy stays low", busy, 1'b0);
    wr(0, 32'h080);
    rd(0, d); check("R3 start bit sticky", d[8], 1'b1);

    // R4 R5 R6 R7 full sequence with interrupt
    do_reset();
    wr(0, 32'h190);
    rd(1, d); check("R4 pending", d, 32'h4);
    repeat (3) @(negedge clk);
    rd(1, d); check("R5 waits for idle", d, 32'h4);
    check("R5 busy low", busy, 1'b0);
    bus_idle = 1'b1;
    @(negedge clk);
    bus_idle = 1'b0;
    rd(1, d); check("R5 busy status", d, 32'h8);
    check("R5 busy out", busy, 1'b1);
    repeat (LAT) @(negedge clk);
    check("R6 still busy", busy, 1'b1);
    check("R7 no early irq", irq, 1'b0);
    ucore_done = 1'b1;
    @(negedge clk);
    ucore_done = 1'b0;
    rd(1, d); check("R6 done", d, 32'h1);
    check("R7 irq with done", irq, 1'b1);
    @(negedge clk);
    check("R7 irq one cycle", irq, 1'b0);
    wr(0, 32'h090);
    wr(0, 32'h190);
    bus_idle = 1'b1;
    repeat (3) @(negedge clk);
    rd(1, d); check("R6 done terminal", d, 32'h1);
    check("R7 irq count", irq_cycles, 1);

    // R7 no interrupt when disabled, bus already idle
    do_reset();
    bus_idle = 1'b1;
    wr(0, 32'h180);
    rd(1, d); check("R5 pending one cycle", d, 32'h4);
    @(negedge clk);
    check("R5 busy next edge", busy, 1'b1);
    ucore_done = 1'b1;
    @(negedge clk);
    ucore_done = 1'b0;
    rd(1, d); check("R6 done no irq", d, 32'h1);
    repeat (2) @(negedge clk);
    check("R7 irq disabled", irq_cycles, 0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule